// File: doc/BRIEF.md
# Cache Miss Entry with Deferred Target Queue

This block is one miss-tracking entry of a cache. It remembers the block address of an outstanding miss and keeps the requests waiting on that block in two small FIFOs. The primary FIFO holds targets that the in-flight fill will satisfy. The deferred FIFO holds targets that must wait for a second request after the fill returns. Each FIFO keeps two summary flags: one says that some target needs write ownership, and one says that some target is an ownership upgrade.

The controlling cache logic drives one operation per cycle. The operations are: allocate, add a target, mark in service (with an optional hint that a dirty or owned response is coming), fill response, promote deferred targets, exclusive copy arrived, and release. Two single-cycle inputs stand in for the coherence logic. They set the pending-invalidate and pending-downgrade state that decides where a new target goes. If several operation inputs are high together, the first in this list wins: allocate, add target, mark in service, response, promote, exclusive arrival, release.

Command codes (3 bits): 0 read, 1 read-exclusive, 2 upgrade, 3 store-conditional upgrade, 4 store-conditional, 5 store-conditional-upgrade-fail, 6 store-conditional-fail, 7 prefetch. Source codes (2 bits): 0 processor, 1 prefetcher.

Top module: `miss_entry`

## Requirements
- R1: After reset the entry is invalid. Both FIFO counts are 0. All flags (in service, pending dirty, pending invalidate, pending downgrade, the four FIFO flags, overflow, promote and release pulses) are 0.
- R2: Allocation captures the address, order tag and ready time, and puts the command in slot 0 of the primary FIFO. The deferred FIFO is emptied and in-service is cleared. The target's source is 1 when the command is 7 (prefetch) and 0 otherwise.
- R3: While the entry is not in service, an added target always goes to the primary FIFO with its command unchanged. Added targets have source 0.
- R4: While in service, an added target goes to the deferred FIFO if any of these holds: the deferred FIFO is non-empty; pending invalidate is set; or the command needs ownership and pending dirty is clear, pending downgrade is set, or the entry was allocated as a forward. Otherwise it goes to the primary FIFO.
- R5: A target sent to the deferred FIFO while pending invalidate is set is rewritten before storage: 2 becomes 1, 3 becomes 5, 4 becomes 6. Other codes are kept.
- R6: Storing a command in 1..6 sets that FIFO's needs-ownership flag. Storing a command in 2..4 sets its upgrade flag. The stored (possibly rewritten) code decides both flags.
- R7: Marking a normal entry in service sets in-service. It sets pending dirty to the primary needs-ownership flag OR the hint, and clears pending invalidate and pending downgrade.
- R8: Marking in service an entry allocated as a forward with no response expected releases it at once: the entry becomes invalid, both counts become 0, and the release output pulses for one cycle.
- R9: A response empties the primary FIFO and leaves its flags unchanged.
- R10: Promote always pulses the acknowledge output. If the primary FIFO is non-empty or nothing is deferred, nothing changes and the success output stays 0. Otherwise the FIFOs swap, the new deferred FIFO's flags clear, in-service clears, the order tag takes the first promoted target's tag, the ready time becomes max(current time, that target's ready time), and the success output is 1.
- R11: On exclusive arrival, if the deferred needs-ownership flag is set and neither pending invalidate nor pending downgrade is set, the deferred targets move in order to the tail of the primary FIFO. The primary needs-ownership flag is set and the deferred FIFO and its flags are cleared. Otherwise nothing changes.
- R12: Each FIFO holds 4 targets. A push into a full FIFO, or an exclusive-arrival move that would exceed 4 entries, is dropped and sets the overflow output, which stays set until reset.
- R13: Release takes effect only when both FIFOs are empty. It then clears valid, in-service, pending dirty and all four FIFO flags in one cycle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate the entry |
| alloc_addr | input | AW | Block address |
| alloc_cmd | input | 3 | First target command |
| alloc_order | input | OW | First target order tag |
| alloc_ready | input | TW | First target ready time |
| alloc_fwd | input | 1 | Entry is a forward |
| alloc_noresp | input | 1 | Forward expects no response |
| tgt_valid | input | 1 | Add a target |
| tgt_cmd | input | 3 | Target command |
| tgt_order | input | OW | Target order tag |
| tgt_ready | input | TW | Target ready time |
| svc_valid | input | 1 | Mark in service |
| svc_dirty_hint | input | 1 | Dirty/owned response expected |
| resp_valid | input | 1 | Fill response, empties primary FIFO |
| promote_valid | input | 1 | Promote deferred targets |
| now | input | TW | Current time |
| excl_valid | input | 1 | Exclusive copy arrived |
| dealloc_valid | input | 1 | Release the entry |
| inv_set | input | 1 | Set pending invalidate |
| dng_set | input | 1 | Set pending downgrade |
| peek_bank | input | 1 | 0 primary, 1 deferred |
| peek_idx | input | 2 | Slot to view |
| entry_valid | output | 1 | Entry allocated |
| in_service | output | 1 | Request issued |
| pending_dirty | output | 1 | Owned response expected |
| post_inv | output | 1 | Pending invalidate |
| post_dng | output | 1 | Pending downgrade |
| blk_addr | output | AW | Block address |
| order_o | output | OW | Entry order tag |
| ready_o | output | TW | Entry ready time |
| prim_cnt | output | 3 | Primary FIFO count |
| def_cnt | output | 3 | Deferred FIFO count |
| prim_excl | output | 1 | Primary needs-ownership flag |
| prim_upg | output | 1 | Primary upgrade flag |
| def_excl | output | 1 | Deferred needs-ownership flag |
| def_upg | output | 1 | Deferred upgrade flag |
| peek_cmd | output | 3 | Viewed slot command |
| peek_order | output | OW | Viewed slot order tag |
| peek_src | output | 2 | Viewed slot source |
| promote_ack | output | 1 | Promote handled (pulse) |
| promote_ok | output | 1 | Promote moved targets (pulse) |
| released | output | 1 | Forward released (pulse) |
| overflow | output | 1 | Sticky overflow |

## Verification
A wrong routing decision in this block shows up one cycle after the add, as a count on the wrong FIFO. A missed command rewrite shows up in the viewed slot contents. Flag errors stay hidden until a later decision: a wrong pending-dirty or needs-ownership bit only surfaces when a later exclusive target is mis-routed, or when an exclusive arrival fails to merge. For that reason the scenarios chain allocation, service, hints and additions before they compare counts. A wrong swap selector corrupts the order tag and ready time in the cycle after promote.

// File: rtl/miss_entry.sv
module miss_entry #(
  parameter int AW    = 32,
  parameter int OW    = 8,
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [AW-1:0]                alloc_addr,
  input  logic [2:0]                   alloc_cmd,
  input  logic [OW-1:0]                alloc_order,
  input  logic [TW-1:0]                alloc_ready,
  input  logic                         alloc_fwd,
  input  logic                         alloc_noresp,
  input  logic                         tgt_valid,
  input  logic [2:0]                   tgt_cmd,
  input  logic [OW-1:0]                tgt_order,
  input  logic [TW-1:0]                tgt_ready,
  input  logic                         svc_valid,
  input  logic                         svc_dirty_hint,
  input  logic                         resp_valid,
  input  logic                         promote_valid,
  input  logic [TW-1:0]                now,
  input  logic                         excl_valid,
  input  logic                         dealloc_valid,
  input  logic                         inv_set,
  input  logic                         dng_set,
  input  logic                         peek_bank,
  input  logic [$clog2(DEPTH)-1:0]     peek_idx,
  output logic                         entry_valid,
  output logic                         in_service,
  output logic                         pending_dirty,
  output logic                         post_inv,
  output logic                         post_dng,
  output logic [AW-1:0]                blk_addr,
  output logic [OW-1:0]                order_o,
  output logic [TW-1:0]                ready_o,
  output logic [$clog2(DEPTH+1)-1:0]   prim_cnt,
  output logic [$clog2(DEPTH+1)-1:0]   def_cnt,
  output logic                         prim_excl,
  output logic                         prim_upg,
  output logic                         def_excl,
  output logic                         def_upg,
  output logic [2:0]                   peek_cmd,
  output logic [OW-1:0]                peek_order,
  output logic [1:0]                   peek_src,
  output logic                         promote_ack,
  output logic                         promote_ok,
  output logic                         released,
  output logic                         overflow
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CTW = $clog2(DEPTH+1);

  logic [2:0]    q_cmd [2][DEPTH];
  logic [OW-1:0] q_ord [2][DEPTH];
  logic [1:0]    q_src [2][DEPTH];
  logic [TW-1:0] q_rdy [2][DEPTH];
  logic [CTW-1:0] cnt [2];
  logic excl_f [2];
  logic upg_f  [2];
  logic psel, is_fwd, is_noresp;

  function automatic logic needs_own(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd6);
  endfunction
  function automatic logic is_upg(input logic [2:0] c);
    return (c >= 3'd2) && (c <= 3'd4);
  endfunction
  function automatic logic [2:0] fail_cmd(input logic [2:0] c);
    case (c)
      3'd2:    return 3'd1;
      3'd3:    return 3'd5;
      3'd4:    return 3'd6;
      default: return c;
    endcase
  endfunction

  logic p, d;
  assign p = psel;
  assign d = ~psel;

  logic sel_tgt, sel_svc, sel_resp, sel_prom, sel_excl, sel_free;
  assign sel_tgt  = tgt_valid & ~alloc_valid;
  assign sel_svc  = svc_valid & ~alloc_valid & ~tgt_valid;
  assign sel_resp = resp_valid & ~alloc_valid & ~tgt_valid & ~svc_valid;
  assign sel_prom = promote_valid & ~alloc_valid & ~tgt_valid & ~svc_valid & ~resp_valid;
  assign sel_excl = excl_valid & ~alloc_valid & ~tgt_valid & ~svc_valid & ~resp_valid & ~promote_valid;
  assign sel_free = dealloc_valid & ~alloc_valid & ~tgt_valid & ~svc_valid & ~resp_valid
                    & ~promote_valid & ~excl_valid;

  logic defer;
  assign defer = in_service & ((cnt[d] != '0) | post_inv |
                 (needs_own(tgt_cmd) & (~pending_dirty | post_dng | is_fwd)));

  logic       tb;
  logic [2:0] tcmd;
  assign tb   = defer ? d : p;
  assign tcmd = (defer & post_inv) ? fail_cmd(tgt_cmd) : tgt_cmd;

  logic [CTW:0] tot;
  assign tot = {1'b0, cnt[p]} + {1'b0, cnt[d]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid <= 1'b0; in_service <= 1'b0; pending_dirty <= 1'b0;
      post_inv <= 1'b0; post_dng <= 1'b0; blk_addr <= '0; order_o <= '0; ready_o <= '0;
      psel <= 1'b0; is_fwd <= 1'b0; is_noresp <= 1'b0;
      promote_ack <= 1'b0; promote_ok <= 1'b0; released <= 1'b0; overflow <= 1'b0;
      for (int b = 0; b < 2; b++) begin
        cnt[b] <= '0; excl_f[b] <= 1'b0; upg_f[b] <= 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
          q_cmd[b][i] <= '0; q_ord[b][i] <= '0; q_src[b][i] <= '0; q_rdy[b][i] <= '0;
        end
      end
    end else begin
      promote_ack <= 1'b0;
      promote_ok  <= 1'b0;
      released    <= 1'b0;
      if (inv_set) post_inv <= 1'b1;
      if (dng_set) post_dng <= 1'b1;
      if (alloc_valid) begin
        entry_valid <= 1'b1; in_service <= 1'b0; pending_dirty <= 1'b0;
        post_inv <= 1'b0; post_dng <= 1'b0;
        blk_addr <= alloc_addr; order_o <= alloc_order; ready_o <= alloc_ready;
        is_fwd <= alloc_fwd; is_noresp <= alloc_noresp; psel <= 1'b0;
        cnt[0] <= CTW'(1); cnt[1] <= '0;
        excl_f[0] <= needs_own(alloc_cmd); upg_f[0] <= is_upg(alloc_cmd);
        excl_f[1] <= 1'b0; upg_f[1] <= 1'b0;
        q_cmd[0][0] <= alloc_cmd; q_ord[0][0] <= alloc_order; q_rdy[0][0] <= alloc_ready;
        q_src[0][0] <= (alloc_cmd == 3'd7) ? 2'd1 : 2'd0;
      end else if (sel_tgt) begin
        if (cnt[tb] == CTW'(DEPTH)) begin
          overflow <= 1'b1;
        end else begin
          q_cmd[tb][IW'(cnt[tb])] <= tcmd;
          q_ord[tb][IW'(cnt[tb])] <= tgt_order;
          q_rdy[tb][IW'(cnt[tb])] <= tgt_ready;
          q_src[tb][IW'(cnt[tb])] <= 2'd0;
          cnt[tb] <= cnt[tb] + CTW'(1);
          if (needs_own(tcmd)) excl_f[tb] <= 1'b1;
          if (is_upg(tcmd))    upg_f[tb]  <= 1'b1;
        end
      end else if (sel_svc) begin
        if (is_fwd && is_noresp) begin
          entry_valid <= 1'b0; in_service <= 1'b0;
          cnt[0] <= '0; cnt[1] <= '0;
          released <= 1'b1;
        end else begin
          in_service <= 1'b1;
          pending_dirty <= excl_f[p] | svc_dirty_hint;
          post_inv <= 1'b0;
          post_dng <= 1'b0;
        end
      end else if (sel_resp) begin
        cnt[p] <= '0;
      end else if (sel_prom) begin
        promote_ack <= 1'b1;
        if (cnt[p] == '0 && cnt[d] != '0) begin
          promote_ok <= 1'b1;
          psel <= ~psel;
          excl_f[p] <= 1'b0;
          upg_f[p]  <= 1'b0;
          in_service <= 1'b0;
          order_o <= q_ord[d][0];
          ready_o <= (now > q_rdy[d][0]) ? now : q_rdy[d][0];
        end
      end else if (sel_excl) begin
        if (excl_f[d] && !post_inv && !post_dng) begin
          if (tot > (CTW+1)'(DEPTH)) begin
            overflow <= 1'b1;
          end else begin
            for (int i = 0; i < DEPTH; i++) begin
              if (i < int'(cnt[d])) begin
                q_cmd[p][IW'(cnt[p] + CTW'(i))] <= q_cmd[d][i];
                q_ord[p][IW'(cnt[p] + CTW'(i))] <= q_ord[d][i];
                q_rdy[p][IW'(cnt[p] + CTW'(i))] <= q_rdy[d][i];
                q_src[p][IW'(cnt[p] + CTW'(i))] <= q_src[d][i];
              end
            end
            cnt[p] <= CTW'(tot);
            cnt[d] <= '0;
            excl_f[p] <= 1'b1;
            excl_f[d] <= 1'b0;
            upg_f[d]  <= 1'b0;
          end
        end
      end else if (sel_free) begin
        if (cnt[0] == '0 && cnt[1] == '0) begin
          entry_valid <= 1'b0; in_service <= 1'b0; pending_dirty <= 1'b0;
          for (int b = 0; b < 2; b++) begin
            excl_f[b] <= 1'b0; upg_f[b] <= 1'b0;
          end
        end
      end
    end
  end

  logic vb;
  assign vb         = peek_bank ? d : p;
  assign peek_cmd   = q_cmd[vb][peek_idx];
  assign peek_order = q_ord[vb][peek_idx];
  assign peek_src   = q_src[vb][peek_idx];
  assign prim_cnt   = cnt[p];
  assign def_cnt    = cnt[d];
  assign prim_excl  = excl_f[p];
  assign prim_upg   = upg_f[p];
  assign def_excl   = excl_f[d];
  assign def_upg    = upg_f[d];

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r12_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_cnt <= CTW'(DEPTH)) && (def_cnt <= CTW'(DEPTH)));
  a_r7_service: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_svc && !(is_fwd && is_noresp)) |=> (in_service && !post_inv && !post_dng));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    released |-> (!entry_valid && prim_cnt == '0 && def_cnt == '0));
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_prom && prim_cnt != '0) |=> (promote_ack && !promote_ok));
  a_r13_free: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_free && prim_cnt == '0 && def_cnt == '0) |=> (!entry_valid && !in_service));
  a_r9_resp: assert property (@(posedge clk) disable iff (!rst_n)
    sel_resp |=> (prim_cnt == '0 && $stable(prim_excl)));
endmodule

// File: tb/miss_entry_tb.sv
module miss_entry_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic alloc_valid = 0, alloc_fwd = 0, alloc_noresp = 0;
  logic [31:0] alloc_addr = 0;
  logic [2:0] alloc_cmd = 0, tgt_cmd = 0;
  logic [7:0] alloc_order = 0, tgt_order = 0;
  logic [15:0] alloc_ready = 0, tgt_ready = 0, now = 0;
  logic tgt_valid = 0, svc_valid = 0, svc_dirty_hint = 0, resp_valid = 0;
  logic promote_valid = 0, excl_valid = 0, dealloc_valid = 0, inv_set = 0, dng_set = 0;
  logic peek_bank = 0;
  logic [1:0] peek_idx = 0;
  logic entry_valid, in_service, pending_dirty, post_inv, post_dng;
  logic [31:0] blk_addr;
  logic [7:0] order_o, peek_order;
  logic [15:0] ready_o;
  logic [2:0] prim_cnt, def_cnt, peek_cmd;
  logic prim_excl, prim_upg, def_excl, def_upg;
  logic [1:0] peek_src;
  logic promote_ack, promote_ok, released, overflow;

  miss_entry u_dut (.*);

  int checks = 0, errors = 0;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0; tgt_valid = 0; svc_valid = 0; resp_valid = 0; promote_valid = 0;
    excl_valid = 0; dealloc_valid = 0; inv_set = 0; dng_set = 0; svc_dirty_hint = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step(); rst_n = 1;
  endtask

  task automatic alloc(input logic [2:0] c, input int ord, input int rdy, input logic f, input logic nr);
    alloc_valid = 1; alloc_cmd = c; alloc_order = 8'(ord); alloc_ready = 16'(rdy);
    alloc_addr = 32'h40 + 32'(ord); alloc_fwd = f; alloc_noresp = nr; step();
  endtask

  task automatic add(input logic [2:0] c, input int ord, input int rdy);
    tgt_valid = 1; tgt_cmd = c; tgt_order = 8'(ord); tgt_ready = 16'(rdy); step();
  endtask

  task automatic svc(input logic h);
    svc_valid = 1; svc_dirty_hint = h; step();
  endtask

  task automatic peek(input logic b, input int i, output int c, output int o, output int s);
    peek_bank = b; peek_idx = 2'(i); #1;
    c = int'(peek_cmd); o = int'(peek_order); s = int'(peek_src);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valid", entry_valid, 0); check("R1 prim_cnt", prim_cnt, 0);
    check("R1 def_cnt", def_cnt, 0); check("R1 overflow", overflow, 0);
    check("R1 flags", {in_service, pending_dirty, post_inv, post_dng, prim_excl, prim_upg, def_excl, def_upg}, 0);
  endtask

  task automatic t_alloc();
    int c, o, s;
    do_reset();
    alloc(3'd7, 5, 10, 0, 0);
    peek(0, 0, c, o, s);
    check("R2 valid", entry_valid, 1); check("R2 addr", blk_addr, 32'h45);
    check("R2 order", order_o, 5); check("R2 ready", ready_o, 10);
    check("R2 prefetch src", s, 1); check("R2 count", prim_cnt, 1); check("R2 svc", in_service, 0);
    alloc(3'd0, 1, 3, 0, 0);
    peek(0, 0, c, o, s);
    check("R2 cpu src", s, 0);
    inv_set = 1; step();
    add(3'd2, 2, 0);
    peek(0, 1, c, o, s);
    check("R3 primary when idle", prim_cnt, 2); check("R3 no rewrite", c, 2);
    check("R3 src cpu", s, 0);
    check("R6 upgrade flag", prim_upg, 1); check("R6 excl flag", prim_excl, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    alloc(3'd0, 1, 0, 0, 0);
    add(3'd1, 2, 0); add(3'd2, 3, 0);
    svc(0);
    check("R7 dirty from flag", pending_dirty, 1);
    add(3'd0, 4, 0);
    check("R4 read to primary", prim_cnt, 4);
    add(3'd1, 5, 0);
    check("R12 overflow set", overflow, 1); check("R12 count kept", prim_cnt, 4);
    check("R4 excl with dirty pending to primary", def_cnt, 0);
  endtask

  task automatic t_defer_merge();
    int c, o, s;
    do_reset();
    alloc(3'd0, 1, 3, 0, 0);
    svc(0);
    check("R7 dirty clear", pending_dirty, 0);
    add(3'd1, 2, 20);
    check("R4 excl deferred", def_cnt, 1); check("R6 def excl", def_excl, 1);
    add(3'd0, 3, 0);
    check("R4 nonempty deferred", def_cnt, 2); check("R4 primary kept", prim_cnt, 1);
    excl_valid = 1; step();
    check("R11 merged count", prim_cnt, 3); check("R11 def empty", def_cnt, 0);
    check("R11 prim excl", prim_excl, 1); check("R11 def excl clear", def_excl, 0);
    peek(0, 1, c, o, s); check("R11 order slot1", o, 2);
    peek(0, 2, c, o, s); check("R11 order slot2", o, 3);
  endtask

  task automatic t_promote();
    do_reset();
    alloc(3'd1, 1, 0, 0, 0);
    svc(0);
    dng_set = 1; step();
    add(3'd1, 7, 50);
    check("R4 downgrade defers", def_cnt, 1);
    excl_valid = 1; step();
    check("R11 blocked by downgrade", def_cnt, 1);
    promote_valid = 1; now = 16'd30; step();
    check("R10 busy ack", promote_ack, 1); check("R10 busy not ok", promote_ok, 0);
    check("R10 busy kept", def_cnt, 1);
    resp_valid = 1; step();
    check("R9 primary empty", prim_cnt, 0); check("R9 flag kept", prim_excl, 1);
    promote_valid = 1; now = 16'd30; step();
    check("R10 ok", promote_ok, 1); check("R10 prim", prim_cnt, 1); check("R10 def", def_cnt, 0);
    check("R10 order", order_o, 7); check("R10 ready max", ready_o, 50);
    check("R10 def flags cleared", def_excl, 0); check("R10 not in service", in_service, 0);
    resp_valid = 1; step();
    promote_valid = 1; step();
    check("R10 nothing deferred", promote_ok, 0); check("R10 ack", promote_ack, 1);
    dealloc_valid = 1; step();
    check("R13 released", entry_valid, 0);
    check("R13 flags cleared", {prim_excl, prim_upg, def_excl, def_upg, pending_dirty}, 0);
  endtask

  task automatic t_rewrite();
    int c, o, s;
    do_reset();
    alloc(3'd0, 1, 0, 0, 0);
    svc(0);
    inv_set = 1; step();
    add(3'd2, 2, 0); add(3'd3, 3, 0); add(3'd4, 4, 0); add(3'd0, 5, 0);
    peek(1, 0, c, o, s); check("R5 upgrade", c, 1);
    peek(1, 1, c, o, s); check("R5 sc upgrade", c, 5);
    peek(1, 2, c, o, s); check("R5 store cond", c, 6);
    peek(1, 3, c, o, s); check("R5 read kept", c, 0);
    check("R6 rewritten no upg", def_upg, 0); check("R6 rewritten excl", def_excl, 1);
    excl_valid = 1; step();
    check("R11 blocked by invalidate", def_cnt, 4);
    add(3'd0, 6, 0);
    check("R12 deferred full", overflow, 1);
    dng_set = 1; step();
    svc(0);
    check("R7 clears inv", post_inv, 0); check("R7 clears dng", post_dng, 0);
    dealloc_valid = 1; step();
    check("R13 ignored nonempty", entry_valid, 1);
  endtask

  task automatic t_forward();
    do_reset();
    alloc(3'd1, 1, 0, 1, 0);
    svc(1);
    check("R7 hint", pending_dirty, 1);
    add(3'd1, 2, 0);
    check("R4 forward defers", def_cnt, 1);
    alloc(3'd0, 3, 0, 1, 1);
    svc_valid = 1; @(posedge clk); @(negedge clk); svc_valid = 0;
    check("R8 pulse", released, 1); check("R8 invalid", entry_valid, 0);
    check("R8 count", prim_cnt, 0);
    step();
    check("R8 pulse ends", released, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_alloc(); t_overflow(); t_defer_merge();
        t_promote(); t_rewrite(); t_forward();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got 1 expected 0");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule